// File: doc/BRIEF.md
# Dual-Side Doorbell Interrupt Register

This block holds a set of doorbell flags that two bus agents share. The remote agent rings the doorbell through the host-side port. Each data bit it writes as one raises the matching flag. The local agent answers through the local-side port. Each data bit it writes as one lowers the matching flag. While any flag is raised, a level interrupt goes to the local agent. Both ports can read the flags at any time.

A test-mode input changes what a local-side write does. With test mode on, the local port becomes an ordinary read/write register, so software can place any pattern in the flags. Host-side writes keep their set-only behaviour in both modes. Both ports are simple single-cycle write strobes with a data word, and they run on one clock. When both ports write the same flag in the same cycle, a new ring is never lost.

Top module: `dbell_reg`

## Requirements
- R1: While reset is asserted, every flag reads 0 on both read ports and the interrupt output is 0.
- R2: A host-side write raises each flag whose data bit is 1. Flags whose data bit is 0 keep their value. The change is visible on the read ports after the next rising clock edge.
- R3: In normal mode (test input 0), a local-side write lowers each flag whose data bit is 1. Flags whose data bit is 0 keep their value.
- R4: If a host-side raise and a local-side lower target the same flag in the same cycle, the flag ends up raised.
- R5: The interrupt output is a register that holds the OR of all flags as they stood before the latest clock edge. It is 1 one cycle after any flag is raised, and it stays 1 until one cycle after the last flag is lowered.
- R6: In test mode (test input 1), a local-side write loads its data word into all flags, raising or lowering each one.
- R7: In test mode, host-side writes still only raise flags. When both ports write in the same cycle, the result is the local data ORed with the host data.
- R8: Both read ports show the current flag value, combinationally. A write in the same cycle does not change the read data until after the clock edge.
- R9: In a cycle with no write strobe, every flag keeps its value whatever the data inputs and the test input carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both ports |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| test_mode | input | 1 | 1 makes local-side writes a direct load |
| host_wr | input | 1 | Host-side write strobe, one cycle per write |
| host_wdata | input | 32 | Host-side write data, ones raise flags |
| host_rdata | output | 32 | Host-side read data, the current flags |
| loc_wr | input | 1 | Local-side write strobe, one cycle per write |
| loc_wdata | input | 32 | Local-side write data, ones lower flags (or load them in test mode) |
| loc_rdata | output | 32 | Local-side read data, the current flags |
| irq | output | 1 | Level interrupt to the local agent |

## Verification
Directed cycles first drive single-port patterns: sparse raises, partial lowers and idle cycles with noisy data. These separate set-only and clear-only behaviour from the hold path. Same-flag collisions, with and without test mode, show whether the raise wins and whether test-mode loads are ORed with the host mask. The walk from zero flags to one flag and back to zero shows that the interrupt lags by one cycle. A long random run follows. It mixes both strobes, their collisions, all-ones and all-zeros words, and test-mode toggles. The bench compares every cycle with a reference model, which exposes any wrong combination of the three update paths.

// File: rtl/dbell_pkg.sv
package dbell_pkg;

  // Update rule applied by each flag cell
  typedef enum logic {
    MODE_NORMAL = 1'b0,
    MODE_TEST   = 1'b1
  } cell_mode_e;

  localparam int unsigned DB_W_DEFAULT = 32;

endpackage

// File: rtl/dbell_rst_sync.sv
module dbell_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/dbell_cell.sv
module dbell_cell
  import dbell_pkg::*;
(
  input  cell_mode_e mode,
  input  logic       cur,
  input  logic       host_set,
  input  logic       loc_wr,
  input  logic       loc_bit,
  output logic       nxt
);

  logic keep_val;

  always_comb begin
    unique case (mode)
      MODE_TEST:   keep_val = loc_wr ? loc_bit : cur;
      default:     keep_val = cur & ~(loc_wr & loc_bit);
    endcase
    // a raise from the host always wins over the local side
    nxt = host_set | keep_val;
  end

endmodule

// File: rtl/dbell_next.sv
module dbell_next
  import dbell_pkg::*;
#(
  parameter int unsigned W = DB_W_DEFAULT
) (
  input  logic         test_mode,
  input  logic [W-1:0] cur,
  input  logic         host_wr,
  input  logic [W-1:0] host_wdata,
  input  logic         loc_wr,
  input  logic [W-1:0] loc_wdata,
  output logic [W-1:0] nxt,
  output logic         upd_en
);

  cell_mode_e   mode;
  logic [W-1:0] host_mask;

  assign mode      = test_mode ? MODE_TEST : MODE_NORMAL;
  assign host_mask = host_wr ? host_wdata : '0;
  assign upd_en    = host_wr | loc_wr;

  for (genvar i = 0; i < W; i++) begin : g_cell
    dbell_cell u_cell (
      .mode     (mode),
      .cur      (cur[i]),
      .host_set (host_mask[i]),
      .loc_wr   (loc_wr),
      .loc_bit  (loc_wdata[i]),
      .nxt      (nxt[i])
    );
  end

endmodule

// File: rtl/dbell_irq.sv
module dbell_irq #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] flags,
  output logic         irq
);

  logic irq_d;
  logic irq_q;

  always_comb begin
    irq_d = |flags;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
    end else begin
      irq_q <= irq_d;
    end
  end

  assign irq = irq_q;

  // R5
  irq_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> irq == $past(|flags));

endmodule

// File: rtl/dbell_reg.sv
module dbell_reg
  import dbell_pkg::*;
#(
  parameter int unsigned W          = DB_W_DEFAULT,
  parameter int unsigned SYNC_DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         test_mode,
  input  logic         host_wr,
  input  logic [W-1:0] host_wdata,
  output logic [W-1:0] host_rdata,
  input  logic         loc_wr,
  input  logic [W-1:0] loc_wdata,
  output logic [W-1:0] loc_rdata,
  output logic         irq
);

  logic         rst_n_s;
  logic [W-1:0] db_q;
  logic [W-1:0] db_d;
  logic         db_en;

  dbell_rst_sync #(.STAGES(SYNC_DEPTH)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  dbell_next #(.W(W)) u_next (
    .test_mode  (test_mode),
    .cur        (db_q),
    .host_wr    (host_wr),
    .host_wdata (host_wdata),
    .loc_wr     (loc_wr),
    .loc_wdata  (loc_wdata),
    .nxt        (db_d),
    .upd_en     (db_en)
  );

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      db_q <= '0;
    end else if (db_en) begin
      db_q <= db_d;
    end
  end

  dbell_irq #(.W(W)) u_irq (
    .clk   (clk),
    .rst_n (rst_n_s),
    .flags (db_q),
    .irq   (irq)
  );

  assign host_rdata = db_q;
  assign loc_rdata  = db_q;

  // R2
  host_set_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    host_wr |=> ((db_q & $past(host_wdata)) == $past(host_wdata)));

  // R3
  loc_clr_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (loc_wr && !test_mode) |=>
      ((db_q & $past(loc_wdata & ~(host_wr ? host_wdata : '0))) == '0));

  // R4 R7
  test_load_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (loc_wr && test_mode) |=>
      (db_q == $past(loc_wdata | (host_wr ? host_wdata : '0))));

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!host_wr && !loc_wr) |=> $stable(db_q));

endmodule

// File: tb/dbell_reg_test.sv
`timescale 1ns/1ps
module dbell_reg_test;

  typedef struct {
    logic [31:0] db;
    logic        irq;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        test_mode;
  logic        host_wr;
  logic [31:0] host_wdata;
  logic [31:0] host_rdata;
  logic        loc_wr;
  logic [31:0] loc_wdata;
  logic [31:0] loc_rdata;
  logic        irq;

  int          checks   = 0;
  int          failures = 0;
  logic [31:0] model    = '0;
  exp_t        sb[$];

  always #2 clk = ~clk;

  dbell_reg uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .test_mode  (test_mode),
    .host_wr    (host_wr),
    .host_wdata (host_wdata),
    .host_rdata (host_rdata),
    .loc_wr     (loc_wr),
    .loc_wdata  (loc_wdata),
    .loc_rdata  (loc_rdata),
    .irq        (irq)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // driver: applies one cycle of stimulus and queues the expected result
  task automatic step(input bit tm, input bit hw, input logic [31:0] hd,
                      input bit lw, input logic [31:0] ld, input string tag);
    logic [31:0] old_v;
    logic [31:0] hs;
    exp_t        it;
    @(negedge clk);
    test_mode  = tm;
    host_wr    = hw;
    host_wdata = hd;
    loc_wr     = lw;
    loc_wdata  = ld;
    #1;
    old_v = model;
    // R8: same-cycle write not yet visible
    check(host_rdata == old_v, "R8", host_rdata, old_v);
    check(loc_rdata == old_v, "R8", loc_rdata, old_v);
    hs = hw ? hd : 32'h0;
    if (tm) model = hs | (lw ? ld : model);
    else    model = hs | (model & ~(lw ? ld : 32'h0));
    it.db  = model;
    it.irq = |old_v;
    it.tag = tag;
    sb.push_back(it);
  endtask

  // monitor: compares after each edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() > 0) begin
        exp_t it;
        it = sb.pop_front();
        check(host_rdata == it.db, it.tag, host_rdata, it.db);
        check(loc_rdata == it.db, it.tag, loc_rdata, it.db);
        check(irq == it.irq, "R5", {31'h0, irq}, {31'h0, it.irq});
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0; test_mode = 1'b0; host_wr = 1'b0; loc_wr = 1'b0;
    host_wdata = 32'hFFFF_FFFF; loc_wdata = 32'h0;
    repeat (2) @(negedge clk);
    host_wr = 1'b1;
    repeat (2) @(negedge clk);
    // R1: writes held off by reset
    check(host_rdata == 32'h0, "R1", host_rdata, 32'h0);
    check(loc_rdata == 32'h0, "R1", loc_rdata, 32'h0);
    check(irq == 1'b0, "R1", {31'h0, irq}, 32'h0);
    host_wr = 1'b0;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(host_rdata == 32'h0, "R1", host_rdata, 32'h0);

    step(0, 1, 32'h0000_00F1, 0, 32'hFFFF_FFFF, "R2");
    step(0, 1, 32'h8000_0000, 0, 32'h0,         "R2");
    step(1, 0, 32'hFFFF_FFFF, 0, 32'hFFFF_FFFF, "R9");
    step(0, 0, 32'h1234_5678, 0, 32'h0,         "R9");
    step(0, 0, 32'h0,         1, 32'h0000_0011, "R3");
    step(0, 1, 32'h0000_0100, 1, 32'h0000_01F0, "R4");
    step(0, 0, 32'h0,         1, 32'hFFFF_FFFF, "R3");
    step(0, 0, 32'h0,         0, 32'h0,         "R5");
    step(0, 1, 32'h0000_0004, 0, 32'h0,         "R5");
    step(0, 0, 32'h0,         0, 32'h0,         "R5");
    step(1, 0, 32'h0,         1, 32'hDEAD_BEEF, "R6");
    step(1, 0, 32'h0,         1, 32'h0,         "R6");
    step(1, 1, 32'h0F00_0000, 1, 32'h0000_00A5, "R7");
    step(1, 1, 32'h0000_0002, 0, 32'h0,         "R7");
    step(0, 0, 32'h0,         1, 32'hFFFF_FFFF, "R3");
    step(0, 0, 32'h0,         0, 32'h0,         "R5");

    for (int n = 0; n < 3000; n++) begin
      logic [31:0] hd;
      logic [31:0] ld;
      int          sel;
      sel = int'($urandom_range(0, 5));
      hd  = $urandom() & $urandom();
      ld  = $urandom();
      if (sel == 0) ld = hd;
      if (sel == 1) ld = 32'hFFFF_FFFF;
      if (sel == 2) hd = 32'h1 << $urandom_range(0, 31);
      if (sel == 3) ld = 32'h0;
      step($urandom_range(0, 7) == 0, $urandom_range(0, 2) == 0, hd,
           $urandom_range(0, 2) == 0, ld, "random");
    end
    step(0, 0, 32'h0, 0, 32'h0, "R9");
    @(negedge clk);
    @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule